// File: doc/BRIEF.md
# Serialized Interrupt Bus Host Controller

This block is the master of a single-wire, open-drain interrupt bus. It opens every bus cycle with a start frame, then walks a configurable number of three-clock data frames. In the first clock of each data frame it samples the line level that a peripheral places in that frame's slot. When the last frame is done it ends the cycle with a stop frame, latches the collected levels into an interrupt-level vector and pulses a valid strobe.

The width of the stop pulse tells every agent on the bus how the next cycle will begin. In continuous mode the host opens the next cycle by itself, one idle clock after the stop recovery. In quiet mode the line stays released until a peripheral pulls it low for a clock. The host then takes that clock as the first clock of the start frame and drives the rest of it. After reset the host is in continuous idle and runs one cycle without being asked, so that the default request levels are collected. Software puts the block back into continuous mode before a suspend or a change of bus configuration by clearing the mode bit.

The line is modelled as a drive enable plus a drive value (`line_oe`, `line_out`) and a sampled input (`line_in`). The host only ever drives low, except for single high recovery clocks.

Top module: `sirq_host`

## Requirements
- R1: While `rst` is high the line is released (`line_oe`=0), `irq_vec` is all zero and `vec_valid` is 0.
- R2: After `rst` falls the host opens one cycle by itself, with a full-length start frame, whatever `quiet_req` holds.
- R3: A start frame the host opens by itself drives the line low for L clocks, where L is `start_len` clamped to the range 4 to 8. It then drives the line high for exactly one recovery clock and releases it on the next clock.
- R4: The number of data frames N is `frame_cnt` clamped to the range 17 to `MAX_FRAMES`. Each frame is three clocks long and its first clock is the sample clock. The sample clock of frame k is the (2+3k)-th clock after the start recovery clock. A low line in that clock gives `irq_vec[k]`=1, and a high line gives 0.
- R5: `irq_vec` is updated in the clock where the stop frame begins, together with a `vec_valid` pulse one clock wide. Bits k >= N read 0, and the vector holds its value until the next stop frame.
- R6: `quiet_req` is sampled on the last clock of the last data frame. If it is 1 the stop frame is low for 2 clocks, and if it is 0 the stop frame is low for 3 clocks. Either way one high recovery clock follows, and the line is then released.
- R7: After a 3-clock stop, the first low of the next start frame comes exactly two clocks after the stop recovery clock, with one released clock between them.
- R8: After a 2-clock stop the host keeps the line released until it samples it low. It takes that single low clock as the start and then drives L-1 further low clocks before the recovery clock.
- R9: After a 2-clock stop, a low level on the line in the clock that directly follows the stop recovery clock is ignored and opens no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling and driving on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| line_in | input | 1 | Sampled level of the shared line |
| line_oe | output | 1 | Host drives the line when 1 |
| line_out | output | 1 | Level driven while `line_oe` is 1 |
| quiet_req | input | 1 | 1 selects quiet mode for the following cycle, 0 selects continuous mode |
| start_len | input | LW (4) | Requested start frame low length, clamped to 4..8 |
| frame_cnt | input | FCW (6) | Requested data frame count, clamped to 17..MAX_FRAMES |
| irq_vec | output | MAX_FRAMES (32) | Latched request levels, bit k from frame k |
| vec_valid | output | 1 | One-clock pulse when `irq_vec` is updated |

## Verification
The hardest situation to reach is a peripheral that pulls the line low too early in quiet mode, in the single clock right after the stop recovery. At that point the host is between the stop frame and quiet idle. The bench's peripheral model tracks the recovery clock from the line itself and places a one-clock pulse exactly in the following clock. It then watches for several clocks that no start appears before it sends a correctly timed start pulse. Slot responses are timed the same way, by counting from the observed start recovery. This lets clamped frame counts and start lengths be checked without reading any state inside the design.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  // Phases of one bus cycle as seen by the host.
  typedef enum logic [2:0] {
    ST_GAP   = 3'd0,  // released clock after a stop recovery
    ST_IDLEQ = 3'd1,  // quiet mode: waiting for a peripheral start pulse
    ST_START = 3'd2,  // start frame low time
    ST_SREC  = 3'd3,  // start recovery (driven high)
    ST_STA   = 3'd4,  // turnaround before the first data frame
    ST_DATA  = 3'd5,  // data frames, three clocks each
    ST_STOP  = 3'd6,  // stop frame low time
    ST_PREC  = 3'd7   // stop recovery (driven high)
  } sirq_st_e;

endpackage

// File: rtl/sirq_cfg.sv
module sirq_cfg #(
  parameter int MIN_FRAMES = 17,
  parameter int MAX_FRAMES = 32,
  parameter int START_MIN  = 4,
  parameter int START_MAX  = 8,
  parameter int LW         = 4,
  parameter int FCW        = 6
) (
  input  logic [LW-1:0]  start_len,
  input  logic [FCW-1:0] frame_cnt,
  output logic [LW-1:0]  eff_start,
  output logic [FCW-1:0] eff_frames
);

  localparam logic [LW-1:0]  SMIN = LW'(START_MIN);
  localparam logic [LW-1:0]  SMAX = LW'(START_MAX);
  localparam logic [FCW-1:0] FMIN = FCW'(MIN_FRAMES);
  localparam logic [FCW-1:0] FMAX = FCW'(MAX_FRAMES);

  always_comb begin
    if (start_len < SMIN)      eff_start = SMIN;
    else if (start_len > SMAX) eff_start = SMAX;
    else                       eff_start = start_len;
  end

  always_comb begin
    if (frame_cnt < FMIN)      eff_frames = FMIN;
    else if (frame_cnt > FMAX) eff_frames = FMAX;
    else                       eff_frames = frame_cnt;
  end

endmodule

// File: rtl/sirq_seq.sv
module sirq_seq
  import sirq_pkg::*;
#(
  parameter int LW  = 4,
  parameter int FCW = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           line_in,
  input  logic           quiet_req,
  input  logic [LW-1:0]  eff_start,
  input  logic [FCW-1:0] eff_frames,
  output sirq_st_e       st_q,
  output sirq_st_e       st_d,
  output logic [FCW-1:0] frame_idx,
  output logic           sample_en,
  output logic           clear_en,
  output logic           latch_en
);

  logic [LW-1:0]  cnt_q, cnt_d;
  logic [LW-1:0]  len_q, len_d;
  logic [FCW-1:0] nfr_q, nfr_d;
  logic [FCW-1:0] fi_d;
  logic [1:0]     ph_q, ph_d;
  logic           quiet_q, quiet_d;
  logic [LW-1:0]  stop_len;
  logic           last_frame;

  assign stop_len   = quiet_q ? LW'(2) : LW'(3);
  assign last_frame = (frame_idx == (nfr_q - 1'b1));

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    len_d   = len_q;
    nfr_d   = nfr_q;
    fi_d    = frame_idx;
    ph_d    = ph_q;
    quiet_d = quiet_q;
    unique case (st_q)
      ST_GAP: begin
        if (quiet_q) begin
          st_d = ST_IDLEQ;
        end else begin
          st_d  = ST_START;
          cnt_d = '0;
          len_d = eff_start;
          nfr_d = eff_frames;
        end
      end
      ST_IDLEQ: begin
        if (!line_in) begin
          // the peripheral's low clock counts as the first start clock
          st_d  = ST_START;
          cnt_d = LW'(1);
          len_d = eff_start;
          nfr_d = eff_frames;
        end
      end
      ST_START: begin
        if ((cnt_q + 1'b1) >= len_q) st_d = ST_SREC;
        else                          cnt_d = cnt_q + 1'b1;
      end
      ST_SREC: st_d = ST_STA;
      ST_STA: begin
        st_d = ST_DATA;
        fi_d = '0;
        ph_d = '0;
      end
      ST_DATA: begin
        if (ph_q == 2'd2) begin
          ph_d = '0;
          if (last_frame) begin
            st_d    = ST_STOP;
            cnt_d   = '0;
            quiet_d = quiet_req;
          end else begin
            fi_d = frame_idx + 1'b1;
          end
        end else begin
          ph_d = ph_q + 1'b1;
        end
      end
      ST_STOP: begin
        if ((cnt_q + 1'b1) >= stop_len) st_d = ST_PREC;
        else                             cnt_d = cnt_q + 1'b1;
      end
      ST_PREC: st_d = ST_GAP;
      default: st_d = ST_GAP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_GAP;
      cnt_q     <= '0;
      len_q     <= LW'(4);
      nfr_q     <= '0;
      frame_idx <= '0;
      ph_q      <= '0;
      quiet_q   <= 1'b0;   // continuous idle after reset
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      len_q     <= len_d;
      nfr_q     <= nfr_d;
      frame_idx <= fi_d;
      ph_q      <= ph_d;
      quiet_q   <= quiet_d;
    end
  end

  assign sample_en = (st_q == ST_DATA) && (ph_q == 2'd0);
  assign clear_en  = (st_d == ST_START) && (st_q != ST_START);
  assign latch_en  = (st_q == ST_DATA) && (ph_q == 2'd2) && last_frame;

  // R4: the frame index never runs past the latched frame count
  p_frame_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DATA) |-> (frame_idx < nfr_q));

  // R6: quiet stop is two low clocks, continuous stop is three
  p_quiet_stop_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PREC && quiet_q) |->
      ($past(st_q) == ST_STOP && $past(st_q, 2) == ST_STOP && $past(st_q, 3) == ST_DATA));
  p_cont_stop_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PREC && !quiet_q) |->
      ($past(st_q) == ST_STOP && $past(st_q, 3) == ST_STOP && $past(st_q, 4) == ST_DATA));

  // R3: every start frame has at least three host low clocks before recovery
  p_start_len_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SREC) |-> ($past(st_q, 3) == ST_START));

  // R7: continuous mode opens the next cycle right after the released clock
  p_cont_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_GAP && !quiet_q) |=> (st_q == ST_START));

  // R8: quiet idle holds while the line stays high
  p_quiet_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLEQ && line_in) |=> (st_q == ST_IDLEQ));

  // R9: the clock after the stop recovery never opens a quiet cycle
  p_early_ignore_r9: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_GAP && quiet_q) |=> (st_q == ST_IDLEQ));

endmodule

// File: rtl/sirq_capture.sv
module sirq_capture #(
  parameter int MAX_FRAMES = 32,
  parameter int FCW        = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  line_in,
  input  logic [FCW-1:0]        frame_idx,
  input  logic                  sample_en,
  input  logic                  clear_en,
  input  logic                  latch_en,
  output logic [MAX_FRAMES-1:0] irq_vec,
  output logic                  vec_valid
);

  logic [MAX_FRAMES-1:0] shadow_q;

  // One capture flop per slot; a low line in the sample clock means requested.
  for (genvar k = 0; k < MAX_FRAMES; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || clear_en)
        shadow_q[k] <= 1'b0;
      else if (sample_en && (frame_idx == FCW'(k)))
        shadow_q[k] <= ~line_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_vec   <= '0;
      vec_valid <= 1'b0;
    end else begin
      vec_valid <= latch_en;
      if (latch_en) irq_vec <= shadow_q;
    end
  end

  // R5: the valid strobe is one clock wide
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    vec_valid |=> !vec_valid);

  // R5: the vector only moves together with the strobe
  p_vec_stable_r5: assert property (@(posedge clk) disable iff (rst)
    !vec_valid |-> $stable(irq_vec));

endmodule

// File: rtl/sirq_line_drv.sv
module sirq_line_drv
  import sirq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  sirq_st_e st_d,
  output logic     line_oe,
  output logic     line_out
);

  logic oe_d, out_d;

  always_comb begin
    oe_d  = (st_d == ST_START) || (st_d == ST_SREC) ||
            (st_d == ST_STOP)  || (st_d == ST_PREC);
    out_d = (st_d == ST_SREC) || (st_d == ST_PREC);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_oe  <= 1'b0;
      line_out <= 1'b0;
    end else begin
      line_oe  <= oe_d;
      line_out <= out_d;
    end
  end

  // R3/R6: a high recovery clock is always followed by release
  p_recover_release_r3: assert property (@(posedge clk) disable iff (rst)
    (line_oe && line_out) |=> !line_oe);

  // R3/R6: the host drives high only right after it has driven low
  p_high_after_low_r6: assert property (@(posedge clk) disable iff (rst)
    (line_oe && line_out) |-> ($past(line_oe) && !$past(line_out)));

endmodule

// File: rtl/sirq_host.sv
module sirq_host
  import sirq_pkg::*;
#(
  parameter int  MAX_FRAMES = 32,
  parameter int  MIN_FRAMES = 17,
  parameter int  START_MIN  = 4,
  parameter int  START_MAX  = 8,
  localparam int LW         = $clog2(START_MAX + 1),
  localparam int FCW        = $clog2(MAX_FRAMES + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  line_in,
  output logic                  line_oe,
  output logic                  line_out,
  input  logic                  quiet_req,
  input  logic [LW-1:0]         start_len,
  input  logic [FCW-1:0]        frame_cnt,
  output logic [MAX_FRAMES-1:0] irq_vec,
  output logic                  vec_valid
);

  logic [LW-1:0]  eff_start;
  logic [FCW-1:0] eff_frames;
  sirq_st_e       st_q, st_d;
  logic [FCW-1:0] frame_idx;
  logic           sample_en, clear_en, latch_en;

  sirq_cfg #(
    .MIN_FRAMES(MIN_FRAMES), .MAX_FRAMES(MAX_FRAMES),
    .START_MIN(START_MIN),   .START_MAX(START_MAX),
    .LW(LW),                 .FCW(FCW)
  ) u_cfg (
    .start_len (start_len),
    .frame_cnt (frame_cnt),
    .eff_start (eff_start),
    .eff_frames(eff_frames)
  );

  sirq_seq #(.LW(LW), .FCW(FCW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .line_in   (line_in),
    .quiet_req (quiet_req),
    .eff_start (eff_start),
    .eff_frames(eff_frames),
    .st_q      (st_q),
    .st_d      (st_d),
    .frame_idx (frame_idx),
    .sample_en (sample_en),
    .clear_en  (clear_en),
    .latch_en  (latch_en)
  );

  sirq_capture #(.MAX_FRAMES(MAX_FRAMES), .FCW(FCW)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .line_in  (line_in),
    .frame_idx(frame_idx),
    .sample_en(sample_en),
    .clear_en (clear_en),
    .latch_en (latch_en),
    .irq_vec  (irq_vec),
    .vec_valid(vec_valid)
  );

  sirq_line_drv u_drv (
    .clk     (clk),
    .rst     (rst),
    .st_d    (st_d),
    .line_oe (line_oe),
    .line_out(line_out)
  );

  // R4: the host never drives during the data frames
  p_data_released_r4: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DATA) |-> !line_oe);

  // R5: a new vector appears exactly as the stop frame begins
  p_latch_at_stop_r5: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> (st_q == ST_STOP && line_oe && !line_out));

  // R1: the first clock after reset never drives the line
  p_reset_release_r1: assert property (@(posedge clk)
    $past(rst) |-> !line_oe);

endmodule

// File: tb/sirq_host_bench.sv
module sirq_host_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MAXF = 32;
  localparam int MINF = 17;
  localparam int SMIN = 4;
  localparam int SMAX = 8;
  localparam int LW   = $clog2(SMAX + 1);
  localparam int FCW  = $clog2(MAXF + 1);

  typedef struct packed {
    logic           q;
    logic [LW-1:0]  sl;
    logic [FCW-1:0] fc;
    logic [31:0]    pat;
  } ent_t;

  localparam int NENT = 8;
  localparam ent_t TAB [NENT] = '{
    '{1'b0, 4'd4,  6'd17, 32'h0001_5A5A},
    '{1'b0, 4'd8,  6'd17, 32'h0001_FFFF},
    '{1'b1, 4'd6,  6'd20, 32'h000F_0001},
    '{1'b0, 4'd5,  6'd32, 32'hFFFF_FFFF},
    '{1'b0, 4'd2,  6'd10, 32'hFFFF_FFFF},
    '{1'b1, 4'd15, 6'd40, 32'h8000_0001},
    '{1'b1, 4'd7,  6'd17, 32'h0000_0000},
    '{1'b0, 4'd4,  6'd17, 32'h0000_AAAA}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic quiet_req = 1'b0;
  logic [LW-1:0]  start_len = '0;
  logic [FCW-1:0] frame_cnt = '0;
  logic slot_low = 1'b0;
  logic pulse_low = 1'b0;
  logic line_in, line_oe, line_out, vec_valid;
  logic [MAXF-1:0] irq_vec;

  assign line_in = ~((line_oe & ~line_out) | slot_low | pulse_low);

  always #(CLK_PERIOD/2) clk = ~clk;

  sirq_host u_sirq_host (
    .clk(clk), .rst(rst), .line_in(line_in), .line_oe(line_oe),
    .line_out(line_out), .quiet_req(quiet_req), .start_len(start_len),
    .frame_cnt(frame_cnt), .irq_vec(irq_vec), .vec_valid(vec_valid)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Line monitor and peripheral model, evaluated mid-cycle.
  int cyc = 0, run = 0, start_run = 0, stop_run = 0;
  int starts = 0, stops = 0, rec_cyc = 0, gap = -1, rel = 0, valids = 0;
  int bad_release = 0;
  bit in_cyc = 0, have_rec = 0, was_rec = 0;
  logic [31:0] cur_pat = '0;
  int cur_cnt = MINF;

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      run = 0; in_cyc = 0; have_rec = 0; rel = 0; was_rec = 0;
      slot_low = 1'b0;
    end else begin
      if (vec_valid) valids++;
      if (was_rec && line_oe) bad_release++;
      was_rec = 0;
      if (in_cyc) rel++;
      if (line_oe && !line_out) begin
        if (run == 0 && have_rec) begin
          gap = cyc - rec_cyc - 1;
          have_rec = 0;
        end
        run++;
      end else begin
        if (line_oe && line_out && run > 0) begin
          was_rec = 1;
          if (!in_cyc) begin
            start_run = run; starts++; rel = 0; in_cyc = 1;
          end else begin
            stop_run = run; stops++; rec_cyc = cyc; have_rec = 1; in_cyc = 0;
          end
        end
        run = 0;
      end
      slot_low = 1'b0;
      if (in_cyc && rel >= 2 && ((rel - 2) % 3) == 0) begin
        if (((rel - 2) / 3) < cur_cnt && cur_pat[(rel - 2) / 3])
          slot_low = 1'b1;
      end
    end
  end

  function automatic int eff_l(input logic [LW-1:0] sl);
    if (int'(sl) < SMIN) return SMIN;
    if (int'(sl) > SMAX) return SMAX;
    return int'(sl);
  endfunction

  function automatic int eff_n(input logic [FCW-1:0] fc);
    if (int'(fc) < MINF) return MINF;
    if (int'(fc) > MAXF) return MAXF;
    return int'(fc);
  endfunction

  function automatic logic [63:0] exp_vec(input logic [31:0] pat, input int n);
    logic [63:0] m;
    m = (64'd1 << n) - 64'd1;
    return {32'd0, pat} & m;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic q, input logic [LW-1:0] sl,
                       input logic [FCW-1:0] fc, input logic [31:0] pat);
    quiet_req = q; start_len = sl; frame_cnt = fc;
    cur_pat = pat; cur_cnt = eff_n(fc);
  endtask

  task automatic wait_stop(input string req);
    int s0;
    int v0;
    bit seen;
    s0 = stops; v0 = valids; seen = 0;
    for (int t = 0; t < 400 && !seen; t++) begin
      @(negedge clk); #1;
      if (stops != s0) seen = 1;
    end
    chk({req, " stop frame reached"}, 64'(seen), 64'd1);
    chk("R5 one valid pulse per cycle", 64'(valids - v0), 64'd1);
  endtask

  task automatic quiet_pulse();
    pulse_low = 1'b1;
    @(negedge clk); #1;
    pulse_low = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] hold_vec;
    int s0;
    apply(TAB[0].q, TAB[0].sl, TAB[0].fc, TAB[0].pat);
    repeat (4) @(negedge clk);
    #1;
    // R1: reset state
    chk("R1 line released in reset", 64'(line_oe), 64'd0);
    chk("R1 vector clear in reset", 64'(irq_vec), 64'd0);
    chk("R1 valid low in reset", 64'(vec_valid), 64'd0);
    rst = 1'b0;

    // Table walk: each entry configures one bus cycle.
    for (int i = 0; i < NENT; i++) begin
      bit prev_q;
      prev_q = (i > 0) ? TAB[i-1].q : 1'b0;
      wait_stop("R4");
      if (i == 0)
        chk("R2 initial cycle full start", 64'(start_run), 64'(eff_l(TAB[i].sl)));
      else if (prev_q)
        chk("R8 quiet start host lows", 64'(start_run), 64'(eff_l(TAB[i].sl) - 1));
      else begin
        chk("R3 start low length", 64'(start_run), 64'(eff_l(TAB[i].sl)));
        chk("R7 continuous restart gap", 64'(gap), 64'd1);
      end
      chk("R6 stop low length", 64'(stop_run), TAB[i].q ? 64'd2 : 64'd3);
      chk("R4 R5 latched vector", 64'(irq_vec), exp_vec(TAB[i].pat, eff_n(TAB[i].fc)));
      hold_vec = irq_vec;
      if (i < NENT - 1) apply(TAB[i+1].q, TAB[i+1].sl, TAB[i+1].fc, TAB[i+1].pat);
      if (TAB[i].q) begin
        // R9: early pulse right after the stop recovery clock
        s0 = starts;
        @(negedge clk); #1;
        pulse_low = 1'b1;
        @(negedge clk); #1;
        pulse_low = 1'b0;
        repeat (8) @(negedge clk);
        #1;
        chk("R9 early low opens no cycle", 64'(starts - s0), 64'd0);
        chk("R9 line stays released", 64'(line_oe), 64'd0);
        chk("R5 vector held between stops", 64'(irq_vec), 64'(hold_vec));
        quiet_pulse();
      end
    end

    // Directed: reset mid-cycle, then mode bit already quiet.
    repeat (20) @(negedge clk);
    #1;
    apply(1'b1, 4'd6, 6'd18, 32'h0002_0003);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 mid-cycle reset releases line", 64'(line_oe), 64'd0);
    chk("R1 mid-cycle reset clears vector", 64'(irq_vec), 64'd0);
    rst = 1'b0;
    wait_stop("R2");
    chk("R2 initial cycle ignores quiet bit", 64'(start_run), 64'd6);
    chk("R2 R4 default levels collected", 64'(irq_vec), exp_vec(32'h0002_0003, 18));
    chk("R6 quiet stop length", 64'(stop_run), 64'd2);

    // R8: quiet idle waits for a peripheral
    s0 = starts;
    repeat (30) @(negedge clk);
    #1;
    chk("R8 no start without peripheral", 64'(starts - s0), 64'd0);
    apply(1'b0, 4'd6, 6'd18, 32'h0000_0F0F);
    quiet_pulse();
    wait_stop("R8");
    chk("R8 start completed by host", 64'(start_run), 64'd5);
    chk("R6 back to continuous stop", 64'(stop_run), 64'd3);
    chk("R4 vector after quiet start", 64'(irq_vec), exp_vec(32'h0000_0F0F, 18));

    // R7: continuous mode resumes without any peripheral
    wait_stop("R7");
    chk("R7 self restart gap", 64'(gap), 64'd1);
    chk("R3 self restart start length", 64'(start_run), 64'd6);
    chk("R3 R6 release after each recovery", 64'(bad_release), 64'd0);

    finish_run();
  end

endmodule